// File: doc/BRIEF.md
# IDE Controller Configuration Register Space

This block holds the 256-byte configuration space of a dual-channel IDE controller that has bus-master DMA. A host-side access port reads or writes one to four consecutive bytes per cycle. Read data is packed little-endian and returned one cycle later. Each byte offset carries its own write rule. Identity bytes are constant. Some ranges drop every write. The command byte keeps only two bits. The low byte of the bus-master base address always carries the I/O-space indicator.

Whenever a write changes either byte of the bus-master base address, the block raises a one-cycle remap strobe. It also presents the decoded 16-byte-aligned I/O base, together with an enable that is true only while I/O decoding is switched on and the base is nonzero. Reset loads the command, status and base defaults. It loads each channel's timing register pair only for the channels marked present.

Top module: `ide_cfg_space`

## Requirements
- R1: During reset and after it, offset 0x04 reads 0x01, 0x06 reads 0x80, 0x07 reads 0x02, 0x20 reads 0x01 and 0x44 reads 0x00. Every byte not named in R1 to R3 reads 0x00. After reset, bm_remap, bm_base and bm_decode_en are 0.
- R2: Reset loads offsets 0x40/0x41 with 0x00/0x80 when chan_present[0] is 1, and offsets 0x42/0x43 with 0x00/0x80 when chan_present[1] is 1. The pair of an absent channel resets to 0x00/0x00.
- R3: Offsets 0x00/0x01 read VENDOR_ID low then high byte, and 0x02/0x03 read DEVICE_ID low then high byte. Offsets 0x09, 0x0A and 0x0B read 0x80, 0x01 and 0x01, and 0x0E reads 0x00. A write never changes any of these bytes.
- R4: A write to offset 0x04 stores the written byte ANDed with 0x05. Writes to offsets 0x05 and 0x06 have no effect.
- R5: A write to offset 0x20 stores bits 7:2 of the written byte and forces bits 1:0 to 2'b01.
- R6: Offsets 0x10 to 0x1F and 0x22 to 0x3F always read 0x00 and are never written. A write whose starting offset lies in either range has no effect on any byte, including bytes beyond the range.
- R7: A read with acc_len from 1 to 4 returns, in the next cycle, byte (acc_addr+i) mod 256 in rd_data bits 8i+7:8i, with the unused upper bytes 0. A read with acc_len 0 returns 0. A read with acc_len 5 to 7 returns 0xFFFFFFFF.
- R8: A write with acc_len from 1 to 4 stores wdata bits 8i+7:8i at offset (acc_addr+i) mod 256, subject to R3 to R6. Every other offset, including the timing bytes and 0x21, stores the whole byte. A write with acc_len 0 or 5 to 7 has no effect.
- R9: In the cycle after a write that changes the stored value of offset 0x20 or 0x21, bm_remap is 1 for exactly one cycle. A write that leaves both bytes unchanged does not raise bm_remap. bm_base always equals {byte 0x21, byte 0x20 bits 7:4, 4'h0}.
- R10: bm_decode_en is 1 exactly when bit 0 of offset 0x04 is 1 and bm_base is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_present | input | 2 | Per-channel presence, sampled while in reset |
| acc_rd | input | 1 | Read request this cycle |
| acc_wr | input | 1 | Write request this cycle |
| acc_addr | input | 8 | Starting byte offset |
| acc_len | input | 3 | Number of bytes in the access |
| acc_wdata | input | 32 | Write data, lowest offset in bits 7:0 |
| rd_data | output | 32 | Read data, valid the cycle after acc_rd |
| bm_base | output | 16 | Decoded bus-master I/O base |
| bm_remap | output | 1 | One-cycle strobe after the base bytes change |
| bm_decode_en | output | 1 | Bus-master I/O decode enable |

## Verification
The assertions assume that chan_present stays constant while rst_n is low. They also assume that at most one of acc_rd and acc_wr is high in a cycle. The read-format assertions further assume that the requester samples rd_data only in the cycle after a request. The stimulus changes inputs only at falling edges and issues every access as a single isolated cycle. It holds chan_present fixed across each reset pulse, so the bench's byte-image model stays exact. It sweeps every offset with single-byte writes and reads, and every length from 0 to 7 at offsets chosen to cross range borders and the 0xFF wrap.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

   typedef enum logic [2:0] {
      RULE_RW,
      RULE_RO,
      RULE_DROP,
      RULE_CMD,
      RULE_BASE
   } byte_rule_e;

   localparam int        CMD_OFF      = 'h04;
   localparam int        BASE_OFF     = 'h20;
   localparam int        TIM_OFF      = 'h40;
   localparam logic [7:0] CMD_KEEP    = 8'h05;
   localparam logic [7:0] BASE_KEEP   = 8'hFC;
   localparam logic [7:0] IO_TAG      = 8'h01;
   localparam logic [7:0] TIM_HI_INIT = 8'h80;

   function automatic logic in_drop(input int off);
      return ((off >= 'h10) && (off <= 'h1F)) || ((off >= 'h22) && (off <= 'h3F));
   endfunction

   function automatic byte_rule_e rule_of(input int off);
      if (in_drop(off))                         return RULE_DROP;
      if (off == CMD_OFF)                       return RULE_CMD;
      if (off == BASE_OFF)                      return RULE_BASE;
      if ((off <= 'h03) || (off == 'h05) || (off == 'h06) ||
          (off == 'h09) || (off == 'h0A) || (off == 'h0B) || (off == 'h0E))
         return RULE_RO;
      return RULE_RW;
   endfunction

   function automatic logic [7:0] fixed_init(input int off, input logic [15:0] ven,
                                             input logic [15:0] dev);
      case (off)
         'h00:    return ven[7:0];
         'h01:    return ven[15:8];
         'h02:    return dev[7:0];
         'h03:    return dev[15:8];
         'h04:    return 8'h01;
         'h06:    return 8'h80;
         'h07:    return 8'h02;
         'h09:    return 8'h80;
         'h0A:    return 8'h01;
         'h0B:    return 8'h01;
         'h20:    return IO_TAG;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/ide_cfg_lane.sv
module ide_cfg_lane
   import ide_cfg_pkg::*;
#(
   parameter byte_rule_e RULE = RULE_RW
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wbyte,
   input  logic [7:0] init_val,
   output logic [7:0] q
);

   localparam bit WRITABLE = (RULE == RULE_RW) || (RULE == RULE_CMD) || (RULE == RULE_BASE);

   logic [7:0] shaped;

   generate
      if (RULE == RULE_CMD) begin : g_cmd
         assign shaped = wbyte & CMD_KEEP;
         assert_cmd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (q & ~CMD_KEEP) == 8'h00);
      end else if (RULE == RULE_BASE) begin : g_base
         assign shaped = (wbyte & BASE_KEEP) | IO_TAG;
         assert_io_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
            q[1:0] == 2'b01);
      end else begin : g_plain
         assign shaped = wbyte;
      end

      if (!WRITABLE) begin : g_fixed
         assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> $stable(q));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)               q <= init_val;
      else if (we && WRITABLE)  q <= shaped;
   end

endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux #(
   parameter int NBYTES  = 256,
   parameter int MAX_LEN = 4,
   parameter int ADDR_W  = 8,
   parameter int LEN_W   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [LEN_W-1:0]     len,
   input  logic [7:0]           cfg [NBYTES],
   output logic [8*MAX_LEN-1:0] rd_data
);

   localparam int DATA_W = 8 * MAX_LEN;

   logic [DATA_W-1:0] gathered;

   always_comb begin
      gathered = '0;
      for (int i = 0; i < MAX_LEN; i++) begin
         if (LEN_W'(i) < len) gathered[8*i +: 8] = cfg[addr + ADDR_W'(i)];
      end
      if (len > LEN_W'(MAX_LEN)) gathered = '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rd_data <= '0;
      else if (rd) rd_data <= gathered;
   end

   assert_long_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (len > LEN_W'(MAX_LEN))) |=> (rd_data == '1));

   assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (len == '0)) |=> (rd_data == '0));

endmodule

// File: rtl/ide_cfg_base_track.sv
module ide_cfg_base_track #(
   parameter int         SPAN_LOG2 = 4,
   parameter logic [15:0] INIT_RAW = 16'h0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  lo_byte,
   input  logic [7:0]  hi_byte,
   input  logic        io_on,
   input  logic        base_touch,
   output logic [15:0] base,
   output logic        remap,
   output logic        decode_en
);

   localparam logic [15:0] ALIGN_MASK = ~((16'd1 << SPAN_LOG2) - 16'd1);

   logic [15:0] raw;
   logic [15:0] prev_raw;

   assign raw = {hi_byte, lo_byte};

   always_ff @(posedge clk) begin
      if (!rst_n) prev_raw <= INIT_RAW;
      else        prev_raw <= raw;
   end

   assign remap     = (raw != prev_raw);
   assign base      = raw & ALIGN_MASK;
   assign decode_en = io_on && (base != 16'h0000);

   assert_remap_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      remap |-> $past(base_touch));

   assert_remap_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (remap && !base_touch) |=> !remap);

endmodule

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
   import ide_cfg_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID = 16'h5A3C,
   parameter logic [15:0] DEVICE_ID = 16'h1E77,
   parameter int          MAX_LEN   = 4,
   parameter int          SPAN_LOG2 = 4,
   parameter int          CHANNELS  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CHANNELS-1:0]         chan_present,
   input  logic                        acc_rd,
   input  logic                        acc_wr,
   input  logic [7:0]                  acc_addr,
   input  logic [$clog2(MAX_LEN):0]    acc_len,
   input  logic [8*MAX_LEN-1:0]        acc_wdata,
   output logic [8*MAX_LEN-1:0]        rd_data,
   output logic [15:0]                 bm_base,
   output logic                        bm_remap,
   output logic                        bm_decode_en
);

   localparam int ADDR_W = 8;
   localparam int NBYTES = 1 << ADDR_W;
   localparam int LEN_W  = $clog2(MAX_LEN) + 1;
   localparam int DATA_W = 8 * MAX_LEN;

   generate
      if (MAX_LEN < 1 || MAX_LEN > 4) begin : g_bad_len
         $error("ide_cfg_space: MAX_LEN must lie in 1..4");
      end
      if (SPAN_LOG2 < 2 || SPAN_LOG2 > 8) begin : g_bad_span
         $error("ide_cfg_space: SPAN_LOG2 must lie in 2..8");
      end
      if (CHANNELS < 1 || CHANNELS > 2) begin : g_bad_ch
         $error("ide_cfg_space: CHANNELS must be 1 or 2");
      end
   endgenerate

   logic       start_drop;
   logic       wr_ok;
   logic [7:0] cfg_q  [NBYTES];
   logic       lane_we[NBYTES];

   assign start_drop = in_drop(int'(acc_addr));
   assign wr_ok      = acc_wr && (acc_len != '0) && (acc_len <= LEN_W'(MAX_LEN)) && !start_drop;

   generate
      for (genvar k = 0; k < NBYTES; k++) begin : g_lane
         localparam byte_rule_e RK = rule_of(k);
         logic [ADDR_W-1:0] rel;
         logic [7:0]        lane_byte;
         logic [7:0]        init_k;

         assign rel        = ADDR_W'(k) - acc_addr;
         assign lane_we[k] = wr_ok && (ADDR_W'(acc_len) > rel);

         always_comb begin
            lane_byte = 8'h00;
            for (int j = 0; j < MAX_LEN; j++) begin
               if (rel == ADDR_W'(j)) lane_byte = acc_wdata[8*j +: 8];
            end
         end

         if (k >= TIM_OFF && k < TIM_OFF + 2*CHANNELS) begin : g_tim
            if (((k - TIM_OFF) % 2) == 1) begin : g_hi
               assign init_k = chan_present[(k - TIM_OFF) / 2] ? TIM_HI_INIT : 8'h00;
            end else begin : g_lo
               assign init_k = 8'h00;
            end
         end else begin : g_fix
            assign init_k = fixed_init(k, VENDOR_ID, DEVICE_ID);
         end

         ide_cfg_lane #(.RULE(RK)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (lane_we[k]),
            .wbyte    (lane_byte),
            .init_val (init_k),
            .q        (cfg_q[k])
         );
      end
   endgenerate

   ide_cfg_rdmux #(
      .NBYTES  (NBYTES),
      .MAX_LEN (MAX_LEN),
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W)
   ) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (acc_rd),
      .addr    (acc_addr),
      .len     (acc_len),
      .cfg     (cfg_q),
      .rd_data (rd_data)
   );

   logic base_touch;
   assign base_touch = lane_we[BASE_OFF] || lane_we[BASE_OFF + 1];

   ide_cfg_base_track #(
      .SPAN_LOG2 (SPAN_LOG2),
      .INIT_RAW  ({8'h00, IO_TAG})
   ) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .lo_byte    (cfg_q[BASE_OFF]),
      .hi_byte    (cfg_q[BASE_OFF + 1]),
      .io_on      (cfg_q[CMD_OFF][0]),
      .base_touch (base_touch),
      .base       (bm_base),
      .remap      (bm_remap),
      .decode_en  (bm_decode_en)
   );

   assert_drop_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && start_drop) |=> !bm_remap);

   assert_short_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && (acc_len == '0)) |=> !bm_remap);

endmodule

// File: tb/test_ide_cfg_space.sv
module test_ide_cfg_space;

   localparam logic [15:0] VEN = 16'h5A3C;
   localparam logic [15:0] DEV = 16'h1E77;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  chan_present = 2'b00;
   logic        acc_rd = 1'b0, acc_wr = 1'b0;
   logic [7:0]  acc_addr = '0;
   logic [2:0]  acc_len = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] rd_data;
   logic [15:0] bm_base;
   logic        bm_remap, bm_decode_en;

   always #5 clk = ~clk;

   ide_cfg_space #(.VENDOR_ID(VEN), .DEVICE_ID(DEV)) i_ide_cfg_space (
      .clk(clk), .rst_n(rst_n), .chan_present(chan_present),
      .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_len(acc_len),
      .acc_wdata(acc_wdata), .rd_data(rd_data), .bm_base(bm_base),
      .bm_remap(bm_remap), .bm_decode_en(bm_decode_en));

   int         checks = 0;
   int         fails  = 0;
   logic [7:0] mdl [256];

   function automatic bit is_drop(int a);
      return (a >= 16 && a < 32) || (a >= 34 && a < 64);
   endfunction

   function automatic bit is_ro(int a);
      return a <= 3 || a == 5 || a == 6 || a == 9 || a == 10 || a == 11 || a == 14;
   endfunction

   function automatic string tag_of(int a);
      if (is_ro(a))              return "R3";
      if (is_drop(a))            return "R6";
      if (a == 4 || a == 5 || a == 6) return "R4";
      if (a == 32)               return "R5";
      return "R8";
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_base();
      return {mdl[33], mdl[32][7:4], 4'h0};
   endfunction

   task automatic do_reset(logic [1:0] p);
      chan_present = p;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
      mdl[0] = VEN[7:0]; mdl[1] = VEN[15:8]; mdl[2] = DEV[7:0]; mdl[3] = DEV[15:8];
      mdl[4] = 8'h01; mdl[6] = 8'h80; mdl[7] = 8'h02;
      mdl[9] = 8'h80; mdl[10] = 8'h01; mdl[11] = 8'h01; mdl[32] = 8'h01;
      if (p[0]) mdl[65] = 8'h80;
      if (p[1]) mdl[67] = 8'h80;
   endtask

   task automatic do_write(int addr, int len, logic [31:0] data);
      logic [15:0] old_raw;
      logic        changed;
      old_raw = {mdl[33], mdl[32]};
      acc_wr = 1'b1; acc_addr = addr[7:0]; acc_len = len[2:0]; acc_wdata = data;
      if (len >= 1 && len <= 4 && !is_drop(addr)) begin
         for (int i = 0; i < len; i++) begin
            int a;
            logic [7:0] b;
            a = (addr + i) & 255;
            b = data[8*i +: 8];
            if (!is_ro(a) && !is_drop(a)) begin
               if (a == 4)       b = b & 8'h05;
               else if (a == 32) b = (b & 8'hFC) | 8'h01;
               mdl[a] = b;
            end
         end
      end
      changed = ({mdl[33], mdl[32]} != old_raw);
      @(negedge clk);
      acc_wr = 1'b0;
      chk("R9 remap", {31'd0, bm_remap}, {31'd0, changed});
      chk("R9 base", {16'd0, bm_base}, {16'd0, exp_base()});
      chk("R10 decode", {31'd0, bm_decode_en},
          {31'd0, (mdl[4][0] && exp_base() != 16'h0)});
   endtask

   task automatic do_read(int addr, int len, string req);
      logic [31:0] exp;
      acc_rd = 1'b1; acc_addr = addr[7:0]; acc_len = len[2:0];
      exp = 32'h0;
      if (len > 4) exp = 32'hFFFF_FFFF;
      else for (int i = 0; i < len; i++) exp[8*i +: 8] = mdl[(addr + i) & 255];
      @(negedge clk);
      acc_rd = 1'b0;
      chk(req, rd_data, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      // R1, R2, R3: reset image with primary channel present
      do_reset(2'b01);
      chk("R1 remap", {31'd0, bm_remap}, 32'd0);
      chk("R1 base", {16'd0, bm_base}, 32'd0);
      chk("R1 decode", {31'd0, bm_decode_en}, 32'd0);
      for (int a = 0; a < 256; a++)
         do_read(a, 1, (a >= 64 && a < 68) ? "R2" : (is_ro(a) ? "R3" : "R1"));

      // R3-R6, R8, R9: single-byte write sweep over every offset
      for (int a = 0; a < 256; a++) do_write(a, 1, {24'h0, 8'(a) ^ 8'hA5});
      for (int a = 0; a < 256; a++) do_read(a, 1, tag_of(a));

      // R6, R8: every length at border offsets, including wrap past 0xFF
      foreach (acc_len[i]) begin end
      for (int l = 0; l < 8; l++) begin
         int pts[12] = '{0, 3, 7, 14, 30, 31, 32, 33, 62, 64, 253, 255};
         for (int p = 0; p < 12; p++) begin
            do_write(pts[p], l, 32'h9E37_79B9 * (pts[p] * 8 + l + 1));
            for (int d = 0; d < 5; d++)
               do_read((pts[p] + d) & 255, 1, l > 4 || l == 0 ? "R8" : tag_of((pts[p] + d) & 255));
         end
      end

      // R7: read lengths 0..7 across the space
      for (int a = 0; a < 256; a += 5)
         for (int l = 0; l < 8; l++) do_read(a, l, "R7");
      do_read(254, 4, "R7 wrap");

      // R9, R10: base and decode scenarios
      do_write(4, 1, 32'h0000_00FF);
      do_write(32, 2, 32'h0000_0000);
      do_write(32, 1, 32'h0000_00C2);
      do_write(32, 1, 32'h0000_00C3);
      do_write(33, 1, 32'h0000_0012);
      do_write(33, 1, 32'h0000_0012);
      do_write(4, 1, 32'h0000_0004);
      do_write(4, 1, 32'h0000_0001);
      do_write(32, 2, 32'h0000_000D);
      do_write(30, 4, 32'h5555_5555);
      do_read(32, 2, "R6 whole drop");

      // R2: secondary channel only, then none
      do_reset(2'b10);
      for (int a = 64; a < 69; a++) do_read(a, 1, "R2");
      do_read(32, 4, "R1");
      do_reset(2'b00);
      do_read(64, 4, "R2");
      do_read(4, 4, "R1");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule